// File: doc/BRIEF.md
# EDID Serial Stream Transmitter

This block holds a display's identification record in a local byte buffer and sends it to a host over a single data line. The host supplies the bit clock, a slow vertical-sync-rate clock of at most 25 kHz, so each period lasts at least 40 µs. The block synchronizes this clock into the system clock domain. On each synchronized rising edge it presents the next data bit. Each byte occupies nine external clock periods: eight data bits, most significant first, then one period in which the line is released. The released period marks the byte boundary for the receiver. Every external clock edge seen while transmitting also raises a one-cycle interrupt pulse for the local CPU.

Before streaming, the CPU fills the buffer with the transmitter disabled. It sets the software-load bit, picks the record length (128 or 256 bytes), writes the start address once and then writes the data bytes back to back. The shared pointer steps forward by itself after each access. When the short record is selected, only the lower half belongs to the stream. The CPU may still use the upper half as scratch storage there, but accesses in that half never move the pointer. The CPU then clears the software-load bit, points the address at zero and raises the transmit enable. The stream loops over the selected length for as long as the enable stays high.

Top module: `edid_stream_tx`

## Requirements
- R1: After reset the data-output enable and the interrupt are low, and the buffer pointer is 0. A data write issued straight after reset, without an address write, lands at location 0.
- R2: While transmitting, each byte uses nine external clock periods. Periods 1 to 8 drive the data bits, bit 7 first and bit 0 last, with the output enable high. In period 9 the output enable is low.
- R3: The data output and its enable change only in the system cycle that follows detection of an external clock rising edge. Detection uses a two-flop synchronizer and an edge detector, and the output changes within 3 system clocks of the external edge.
- R4: For each detected external rising edge while transmit enable is high, the interrupt is high for exactly one system cycle. No interrupt is raised while transmit enable is low.
- R5: The data-output enable is low whenever transmit enable is low, whatever the external clock does.
- R6: The stream starts at the pointer value and advances by one location per byte. With size-select low (short record) it wraps from 127 to 0. With size-select high it wraps from 255 to 0.
- R7: While transmitting is off, a CPU data write stores its byte at the pointer location, and a CPU read returns the byte at the pointer one cycle after the read strobe. With the software-load bit set, the pointer post-increments after every data read or write.
- R8: With size-select low, CPU data accesses at pointer values 128 to 255 work normally but never move the pointer.
- R9: With the software-load bit clear, CPU data accesses do not move the pointer.
- R10: While transmit enable is high, CPU data writes and address writes are ignored: neither the buffer contents nor the stream sequence change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| vclk_in | input | 1 | External serial bit clock, asynchronous to clk |
| xmit_en | input | 1 | Transmit enable |
| sw_load_en | input | 1 | Software-load enable; allows pointer post-increment on CPU accesses |
| size_full | input | 1 | Record length select: 0 = 128 bytes, 1 = 256 bytes |
| cpu_addr_wr | input | 1 | Strobe: load the pointer from cpu_wdata |
| cpu_wr | input | 1 | Strobe: write cpu_wdata at the pointer |
| cpu_rd | input | 1 | Strobe: read the byte at the pointer |
| cpu_wdata | input | 8 | CPU write data, also used as the address value |
| cpu_rdata | output | 8 | CPU read data, valid the cycle after cpu_rd |
| sd_o | output | 1 | Serial data value |
| sd_oe | output | 1 | Serial data drive enable (low means released) |
| irq_o | output | 1 | One-cycle pulse per external clock edge while transmitting |

## Verification
The assertions check the timing relations on every cycle. The output may change, drop its enable, or move the pointer during transmission only in the cycle that carries the interrupt pulse. The enable never rises without transmit enable, and each interrupt lasts one cycle. Only the bench scenarios can show the data itself. They cover bit order within a byte, the wrap point at each record length, post-increment against the software-load bit and the upper half, and the fact that writes made during a stream leave the later bytes untouched. These scenarios sweep the whole buffer at both sizes against an arithmetic byte pattern.

// File: rtl/edid_pkg.sv
package edid_pkg;
  localparam int unsigned EDID_DATA_W = 8;
  localparam int unsigned EDID_ADDR_W = 8;
  // slots per byte: data bits plus one released slot
  localparam int unsigned EDID_SLOTS  = EDID_DATA_W + 1;
  localparam int unsigned EDID_SLOT_W = $clog2(EDID_SLOTS);
endpackage

// File: rtl/edid_vclk_sync.sv
module edid_vclk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  // STAGES synchronizer flops plus one history flop for edge detect
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], async_in};
  end

  generate
    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_d[g];
      end
    end
  endgenerate

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/edid_ptr.sv
module edid_ptr #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              size_full,
  input  logic              sw_load_en,
  input  logic              xmit_en,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              cpu_acc,
  input  logic              byte_done,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam logic [ADDR_W-1:0] FULL_MASK = '1;
  localparam logic [ADDR_W-1:0] HALF_MASK = FULL_MASK >> 1;

  logic [ADDR_W-1:0] ptr_q, ptr_d, mask, ptr_inc;
  logic              in_region;

  always_comb begin
    mask      = size_full ? FULL_MASK : HALF_MASK;
    ptr_inc   = (ptr_q + 1'b1) & mask;
    in_region = size_full | ~ptr_q[ADDR_W-1];
    ptr_d     = ptr_q;
    if (xmit_en) begin
      // the stream owns the pointer; CPU address writes are dropped
      if (byte_done) ptr_d = ptr_inc;
    end else if (addr_wr) begin
      ptr_d = addr_val;
    end else if (cpu_acc && sw_load_en && in_region) begin
      ptr_d = ptr_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/edid_buffer.sv
module edid_buffer #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] cpu_rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q, rdata_d;

  // storage array: no reset, like a RAM macro
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign tx_data   = mem[addr];
  assign cpu_rdata = rdata_q;
endmodule

// File: rtl/edid_shifter.sv
module edid_shifter
  import edid_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xmit_en,
  input  logic              tick,
  input  logic [DATA_W-1:0] byte_in,
  output logic              sd_o,
  output logic              oe_o,
  output logic              irq_o,
  output logic              byte_done
);
  localparam int unsigned SLOT_W = $clog2(DATA_W + 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DATA_W);

  logic [SLOT_W-1:0] idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              sd_q, sd_d, oe_q, oe_d, irq_q, irq_d;

  always_comb begin
    idx_d     = idx_q;
    sh_d      = sh_q;
    sd_d      = sd_q;
    oe_d      = oe_q;
    irq_d     = 1'b0;
    byte_done = 1'b0;
    if (!xmit_en) begin
      idx_d = '0;
      oe_d  = 1'b0;
    end else if (tick) begin
      irq_d = 1'b1;
      if (idx_q == '0) begin
        sd_d  = byte_in[DATA_W-1];
        sh_d  = {byte_in[DATA_W-2:0], 1'b0};
        oe_d  = 1'b1;
        idx_d = idx_q + 1'b1;
      end else if (idx_q == LAST_SLOT) begin
        oe_d      = 1'b0;
        idx_d     = '0;
        byte_done = 1'b1;
      end else begin
        sd_d  = sh_q[DATA_W-1];
        sh_d  = {sh_q[DATA_W-2:0], 1'b0};
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      sh_q  <= '0;
      sd_q  <= 1'b0;
      oe_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      sh_q  <= sh_d;
      sd_q  <= sd_d;
      oe_q  <= oe_d;
      irq_q <= irq_d;
    end
  end

  assign sd_o  = sd_q;
  assign oe_o  = oe_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/edid_stream_tx.sv
module edid_stream_tx
  import edid_pkg::*;
#(
  parameter int unsigned ADDR_W      = EDID_ADDR_W,
  parameter int unsigned DATA_W      = EDID_DATA_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vclk_in,
  input  logic              xmit_en,
  input  logic              sw_load_en,
  input  logic              size_full,
  input  logic              cpu_addr_wr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              sd_o,
  output logic              sd_oe,
  output logic              irq_o
);
  logic              tick;
  logic              byte_done;
  logic              oe_raw;
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] tx_byte;
  logic              buf_wr;

  assign buf_wr = cpu_wr & ~xmit_en;

  edid_vclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (vclk_in),
    .rise_o   (tick)
  );

  edid_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .size_full  (size_full),
    .sw_load_en (sw_load_en),
    .xmit_en    (xmit_en),
    .addr_wr    (cpu_addr_wr),
    .addr_val   (cpu_wdata[ADDR_W-1:0]),
    .cpu_acc    (cpu_wr | cpu_rd),
    .byte_done  (byte_done),
    .ptr_o      (ptr)
  );

  edid_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (buf_wr),
    .rd_en     (cpu_rd),
    .addr      (ptr),
    .wdata     (cpu_wdata),
    .tx_data   (tx_byte),
    .cpu_rdata (cpu_rdata)
  );

  edid_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .xmit_en   (xmit_en),
    .tick      (tick),
    .byte_in   (tx_byte),
    .sd_o      (sd_o),
    .oe_o      (oe_raw),
    .irq_o     (irq_o),
    .byte_done (byte_done)
  );

  // release the line at once when transmission is switched off
  assign sd_oe = oe_raw & xmit_en;
endmodule

// File: rtl/edid_stream_tx_chk.sv
module edid_stream_tx_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xmit_en,
  input logic              sd_o,
  input logic              sd_oe,
  input logic              irq_o,
  input logic [ADDR_W-1:0] ptr
);
  // R5
  oe_needs_xmit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe |-> xmit_en);

  // R4
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(xmit_en));

  // R4
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R3
  data_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_oe && $past(sd_oe) && (sd_o != $past(sd_o))) |-> irq_o);

  // R2
  release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sd_oe) && xmit_en && $past(xmit_en)) |-> irq_o);

  // R10
  ptr_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(xmit_en) && (ptr != $past(ptr))) |-> irq_o);
endmodule

bind edid_stream_tx edid_stream_tx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .xmit_en (xmit_en),
  .sd_o    (sd_o),
  .sd_oe   (sd_oe),
  .irq_o   (irq_o),
  .ptr     (ptr)
);

// File: tb/edid_stream_tx_bench.sv
module edid_stream_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vclk_in = 1'b0;
  logic       xmit_en = 1'b0;
  logic       sw_load_en = 1'b0;
  logic       size_full = 1'b0;
  logic       cpu_addr_wr = 1'b0;
  logic       cpu_wr = 1'b0;
  logic       cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic       sd_o, sd_oe, irq_o;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  edid_stream_tx u_edid_stream_tx (
    .clk(clk), .rst_n(rst_n), .vclk_in(vclk_in), .xmit_en(xmit_en),
    .sw_load_en(sw_load_en), .size_full(size_full), .cpu_addr_wr(cpu_addr_wr),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .sd_o(sd_o), .sd_oe(sd_oe), .irq_o(irq_o)
  );

  always @(posedge clk) if (irq_o) irq_cnt <= irq_cnt + 1;

  function automatic logic [7:0] pat_a(int i);
    return 8'((i * 37 + 5) % 256);
  endfunction
  function automatic logic [7:0] pat_b(int i);
    return 8'((i * 91 + 19) % 256);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_addr(logic [7:0] a);
    @(negedge clk); cpu_addr_wr = 1'b1; cpu_wdata = a;
    @(negedge clk); cpu_addr_wr = 1'b0;
  endtask
  task automatic wr_byte(logic [7:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0;
  endtask
  task automatic rd_byte(output logic [7:0] d);
    @(negedge clk); cpu_rd = 1'b1;
    @(negedge clk); cpu_rd = 1'b0; d = cpu_rdata;
  endtask

  // one external clock period; samples late in the high phase
  task automatic vclk_period(output logic s_d, output logic s_oe);
    @(negedge clk); vclk_in = 1'b1;
    repeat (7) @(negedge clk);
    s_d = sd_o; s_oe = sd_oe;
    vclk_in = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // R2: nine periods, MSB first, ninth released; R4: nine pulses
  task automatic stream_byte(string req, logic [7:0] exp);
    logic [7:0] got;
    logic       d, oe;
    int         oe_bad, irq0;
    got = 8'h00; oe_bad = 0; irq0 = irq_cnt;
    for (int s = 0; s < 9; s++) begin
      vclk_period(d, oe);
      if (s < 8) begin
        got = {got[6:0], d};
        if (oe !== 1'b1) oe_bad++;
      end else if (oe !== 1'b0) oe_bad++;
    end
    check(req, int'(got), int'(exp));
    check("R2 enable pattern", oe_bad, 0);
    check("R4 pulses per byte", irq_cnt - irq0, 9);
  endtask

  initial begin
    logic [7:0] r;
    logic       d, oe;
    int         irq0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 sd_oe", int'(sd_oe), 0);
    check("R1 irq", int'(irq_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 sd_oe after release", int'(sd_oe), 0);
    wr_byte(8'h77);
    set_addr(8'h00);
    rd_byte(r);
    check("R1 pointer zero", int'(r), 'h77);

    // R5/R4: external clock while disabled
    irq0 = irq_cnt;
    for (int k = 0; k < 4; k++) begin
      vclk_period(d, oe);
      check("R5 released while off", int'(oe), 0);
    end
    check("R4 no pulse while off", irq_cnt - irq0, 0);

    // R9: no post-increment without software-load
    set_addr(8'd10);
    wr_byte(8'h11);
    wr_byte(8'h22);
    rd_byte(r);
    check("R9 same location", int'(r), 'h22);

    // R7: bulk load short record and read it back
    sw_load_en = 1'b1;
    set_addr(8'h00);
    for (int i = 0; i < 128; i++) wr_byte(pat_a(i));
    rd_byte(r);
    check("R6 short wrap on load", int'(r), int'(pat_a(0)));
    set_addr(8'h00);
    for (int i = 0; i < 128; i++) begin
      rd_byte(r);
      check("R7 readback", int'(r), int'(pat_a(i)));
    end

    // R8: upper half does not advance
    set_addr(8'd200);
    wr_byte(8'hC3);
    wr_byte(8'h3C);
    rd_byte(r);
    check("R8 upper write stays", int'(r), 'h3C);
    rd_byte(r);
    check("R8 upper read stays", int'(r), 'h3C);

    // stream short record past the wrap
    sw_load_en = 1'b0;
    set_addr(8'h00);
    xmit_en = 1'b1;
    for (int b = 0; b < 130; b++) begin
      if (b == 5) begin
        // R10: writes during transmission are dropped
        set_addr(8'h40);
        wr_byte(8'hAA);
      end
      stream_byte("R6 short sequence", pat_a(b % 128));
    end
    xmit_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 drop on disable", int'(sd_oe), 0);
    set_addr(8'h40);
    rd_byte(r);
    check("R10 buffer untouched", int'(r), int'(pat_a(64)));

    // full record
    size_full = 1'b1;
    sw_load_en = 1'b1;
    set_addr(8'h00);
    for (int i = 0; i < 256; i++) wr_byte(pat_b(i));
    rd_byte(r);
    check("R6 full wrap on load", int'(r), int'(pat_b(0)));
    sw_load_en = 1'b0;
    set_addr(8'h00);
    xmit_en = 1'b1;
    for (int b = 0; b < 258; b++) stream_byte("R6 full sequence", pat_b(b % 256));
    xmit_en = 1'b0;
    repeat (4) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule